// File: doc/BRIEF.md
# Floating-Point Stream Accumulator with Wide Fixed-Point Core

This block sums a stream of 46-bit floating-point values, such as the products of a convolution or of one row of a matrix-vector multiply. It has no floating-point adder in its feedback loop. Each accepted value is first turned into a 140-bit two's-complement fixed-point number with 40 integer bits and 100 fraction bits. That number is added into a fixed-point running sum. When a value marked as the last of a sequence has been added, the sum is turned back into the 46-bit float format and presented for one cycle.

The float word holds the sign in bit 45, an 11-bit biased exponent in bits 44:34 and a 34-bit fraction in bits 33:0. The exponent bias is 1023, and normal numbers carry a hidden leading one. A sequence starts with an accepted input that has its start strobe set. That input replaces the running sum instead of adding to it. The block takes one input per clock and keeps no operand storage, so operands and results exist only in float form outside it.

Top module: `fxacc_top`

## Requirements
- R1: A float word with exponent field e in 1..2047 has the value (-1)^s * (1 + f/2^34) * 2^(e-1023), where s is bit 45, e is bits 44:34 and f is bits 33:0. The running sum is the exact total of the converted inputs.
- R2: An input whose exponent field is zero contributes exactly zero, whatever its sign and fraction bits hold.
- R3: On entry, a magnitude is truncated toward zero at 2^-100. Bits of the significand below that weight are lost before the sign is applied.
- R4: An input whose magnitude is 2^39 or more (exponent field 1062 or above) enters as a magnitude of 2^39 - 2^-100, with its own sign.
- R5: The running sum is a 140-bit two's-complement value with 100 fraction bits. An addition that would leave the range [-2^39, 2^39 - 2^-100] clamps to the nearer bound instead of wrapping.
- R6: An accepted input with inStart high discards the previous sum, so the new sum equals that input alone.
- R7: An accepted input with inStart low adds to the running sum. This holds also after a result has been produced, so a sequence may continue past a last marker.
- R8: When inValid is low, inData, inStart and inLast have no effect on the sum or on the results.
- R9: Each accepted input with inLast high produces exactly one result. outValid is high for one cycle, three rising edges after that input is accepted, counting the accepting edge. Inputs may arrive on every clock.
- R10: The result is the running sum converted to float. Its sign is the sign of the sum, its exponent comes from the position of the leading one of the magnitude, and its fraction is truncated toward zero to 34 bits. A zero sum gives the all-zero word.
- R11: After an asynchronous reset (rstN low), outValid is low and the running sum is zero, so an input accepted without inStart sums from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Qualifies inData, inStart and inLast for this cycle |
| inStart | input | 1 | This input replaces the running sum |
| inLast | input | 1 | Produce a result after this input is added |
| inData | input | 46 | Float operand: sign 45, exponent 44:34, fraction 33:0 |
| outValid | output | 1 | One-cycle pulse marking a result |
| outData | output | 46 | Accumulated result in the same float format |

## Verification
A result is due exactly three rising edges after the edge that accepts its last input: one edge converts the input, one adds it into the sum, and one converts the sum back. The bench keeps its own three-deep record of expected results. It fills the record from the inputs it drove and advances it on every rising edge. At each falling edge it compares outValid and outData with the oldest entry, so a result that is early, late, missing or extra fails in the cycle where it occurs. The model sums in exact 140-bit arithmetic, with the clamps and truncations that the requirements state.

// File: rtl/fxacc_pkg.sv
package fxacc_pkg;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 34;
  localparam int BIAS   = 1023;
  localparam int INT_W  = 40;
  localparam int FRC_W  = 100;

  localparam int FLT_W  = 1 + EXP_W + FRAC_W;
  localparam int ACC_W  = INT_W + FRC_W;
  localparam int SIG_W  = FRAC_W + 1;
  // shift that places significand bit 0 on the fixed-point grid
  localparam int SHIFT0 = BIAS + FRAC_W - FRC_W;
  // first exponent whose magnitude no longer fits in the integer part
  localparam int SAT_EXP = BIAS + INT_W - 1;
  localparam int POS_W  = $clog2(ACC_W);

  typedef struct packed {
    logic capture;  // convert and register the incoming float
    logic accEn;    // fold the registered fixed value into the sum
    logic accClr;   // with accEn: replace the sum instead of adding
    logic emit;     // convert the sum and register the float result
  } fxaccCtl_t;
endpackage

// File: rtl/fxacc_ctrl.sv
module fxacc_ctrl
  import fxacc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inStart,
  input  logic      inLast,
  output fxaccCtl_t ctl,
  output logic      outValid
);
  logic convValid, convStart, convLast;
  logic sumLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convValid <= 1'b0;
      convStart <= 1'b0;
      convLast  <= 1'b0;
      sumLast   <= 1'b0;
      outValid  <= 1'b0;
    end else begin
      convValid <= inValid;
      convStart <= inValid & inStart;
      convLast  <= inValid & inLast;
      sumLast   <= convValid & convLast;
      outValid  <= sumLast;
    end
  end

  always_comb begin
    ctl.capture = inValid;
    ctl.accEn   = convValid;
    ctl.accClr  = convValid & convStart;
    ctl.emit    = sumLast;
  end

  // R9: a result pulse always traces back to an accepted last input
  assert_result_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid && inLast, 3));

  // R9: results are single-cycle pulses unless last inputs were back to back
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(inValid && inLast, 2)) |=> !outValid);

  // R8: an idle input slot never schedules a sum update
  assert_idle_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !ctl.accEn);
endmodule

// File: rtl/fxacc_dpath.sv
module fxacc_dpath
  import fxacc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  fxaccCtl_t        ctl,
  input  logic [FLT_W-1:0] inData,
  output logic [FLT_W-1:0] outData
);
  localparam logic [ACC_W-1:0] MAX_POS = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MAX_NEG = {1'b1, {(ACC_W-1){1'b0}}};

  function automatic logic [ACC_W-1:0] floatToFix(input logic [FLT_W-1:0] f);
    logic [ACC_W-1:0] mag;
    logic [SIG_W-1:0] sig;
    int               expo;
    int               sh;
    sig  = {1'b1, f[FRAC_W-1:0]};
    expo = int'(f[FRAC_W +: EXP_W]);
    sh   = expo - SHIFT0;
    if (expo == 0)              mag = '0;
    else if (expo >= SAT_EXP)   mag = MAX_POS;
    else if (sh >= 0)           mag = ACC_W'(sig) << sh;
    else if (-sh >= SIG_W)      mag = '0;
    else                        mag = ACC_W'(sig) >> (-sh);
    return f[FLT_W-1] ? (~mag + 1'b1) : mag;
  endfunction

  function automatic logic [ACC_W-1:0] satAdd(input logic [ACC_W-1:0] a,
                                              input logic [ACC_W-1:0] b);
    logic [ACC_W:0] wide;
    wide = {a[ACC_W-1], a} + {b[ACC_W-1], b};
    if (wide[ACC_W] != wide[ACC_W-1]) return wide[ACC_W] ? MAX_NEG : MAX_POS;
    return wide[ACC_W-1:0];
  endfunction

  function automatic logic [FLT_W-1:0] fixToFloat(input logic [ACC_W-1:0] a);
    logic [ACC_W-1:0] mag;
    logic [ACC_W-1:0] norm;
    logic [POS_W-1:0] lead;
    logic             sgn;
    sgn  = a[ACC_W-1];
    mag  = sgn ? (~a + 1'b1) : a;
    lead = '0;
    for (int i = 0; i < ACC_W; i++) begin
      if (mag[i]) lead = POS_W'(i);
    end
    if (mag == '0) return '0;
    norm = mag << (ACC_W - 1 - int'(lead));
    return {sgn, EXP_W'(int'(lead) + BIAS - FRC_W), norm[ACC_W-2 -: FRAC_W]};
  endfunction

  logic [ACC_W-1:0] fixReg;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] accBase;
  logic [ACC_W-1:0] accNext;

  always_comb begin
    accBase = ctl.accClr ? '0 : acc;
    accNext = satAdd(accBase, fixReg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fixReg  <= '0;
      acc     <= '0;
      outData <= '0;
    end else begin
      if (ctl.capture) fixReg  <= floatToFix(inData);
      if (ctl.accEn)   acc     <= accNext;
      if (ctl.emit)    outData <= fixToFloat(acc);
    end
  end

  // R2: a zero exponent field enters as exactly zero
  assert_zero_flush_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && inData[FRAC_W +: EXP_W] == '0) |=> fixReg == '0);

  // R6: a start input replaces the sum with its own converted value
  assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.accEn && ctl.accClr) |=> acc == $past(fixReg));

  // R5: two non-negative operands never wrap to a negative sum
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.accEn && !ctl.accClr && !acc[ACC_W-1] && !fixReg[ACC_W-1]) |=> !acc[ACC_W-1]);

  // R5: two negative operands never wrap to a non-negative sum
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.accEn && !ctl.accClr && acc[ACC_W-1] && fixReg[ACC_W-1]) |=> acc[ACC_W-1]);

  // R10: a zero sum yields the all-zero word
  assert_zero_result_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.emit && acc == '0) |=> outData == '0);

  // R10: a non-zero result carries the sign of the sum
  assert_result_sign_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.emit && acc != '0) |=> outData[FLT_W-1] == $past(acc[ACC_W-1]));
endmodule

// File: rtl/fxacc_top.sv
module fxacc_top
  import fxacc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inStart,
  input  logic             inLast,
  input  logic [45:0]      inData,
  output logic             outValid,
  output logic [45:0]      outData
);
  fxaccCtl_t ctl;

  fxacc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inStart  (inStart),
    .inLast   (inLast),
    .ctl      (ctl),
    .outValid (outValid)
  );

  fxacc_dpath u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .inData  (inData),
    .outData (outData)
  );
endmodule

// File: tb/fxacc_top_bench.sv
`timescale 1ns/1ps
module fxacc_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inStart = 1'b0, inLast = 1'b0;
  logic [45:0] inData = '0;
  logic        outValid;
  logic [45:0] outData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string curTag = "R1";

  always #5 clk = ~clk;

  fxacc_top u_fxacc_top (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inStart(inStart),
    .inLast(inLast), .inData(inData), .outValid(outValid), .outData(outData)
  );

  // ---------------- reference model from the requirements ----------------
  function automatic logic [45:0] mk(input bit s, input int e, input logic [33:0] f);
    return {s, 11'(e), f};
  endfunction

  // R1/R2/R3/R4: place each significand bit at weight 2^(e-1023+i-34), grid 2^-100
  function automatic logic [139:0] refToFix(input logic [45:0] f);
    logic [139:0] mag;
    int e;
    e = int'(f[44:34]);
    mag = '0;
    if (e == 0) return '0;
    if (e >= 1062) mag = {1'b0, {139{1'b1}}};
    else begin
      for (int i = 0; i < 35; i++) begin
        bit b;
        int pos;
        b = (i == 34) ? 1'b1 : f[i];
        pos = (e - 1023) + (i - 34) + 100;
        if (b && pos >= 0 && pos < 139) mag[pos] = 1'b1;
      end
    end
    return f[45] ? -mag : mag;
  endfunction

  // R5: exact sum clamped to the signed 140-bit range
  function automatic logic [139:0] refSat(input logic [139:0] a, input logic [139:0] b);
    logic signed [140:0] w;
    logic signed [140:0] hi;
    logic signed [140:0] lo;
    hi = 141'sd1 <<< 139; hi = hi - 1;
    lo = -(141'sd1 <<< 139);
    w = $signed({a[139], a}) + $signed({b[139], b});
    if (w > hi) w = hi;
    if (w < lo) w = lo;
    return w[139:0];
  endfunction

  // R10: leading one gives exponent p-100+1023, next 34 bits the fraction
  function automatic logic [45:0] refToFloat(input logic [139:0] a);
    logic [139:0] mag;
    logic [33:0]  fr;
    int p;
    if (a == '0) return '0;
    mag = a[139] ? -a : a;
    p = -1;
    for (int i = 139; i >= 0; i--) if (p < 0 && mag[i]) p = i;
    fr = '0;
    for (int j = 0; j < 34; j++) if (p - 1 - j >= 0) fr[33 - j] = mag[p - 1 - j];
    return {a[139], 11'(p - 100 + 1023), fr};
  endfunction

  logic [139:0] refAcc = '0;
  bit           e1v = 0, e2v = 0, e3v = 0;
  logic [45:0]  e1d = '0, e2d = '0, e3d = '0;
  string        e1t = "", e2t = "", e3t = "";

  always @(posedge clk) begin
    if (rstN) begin
      e3v = e2v; e3d = e2d; e3t = e2t;
      e2v = e1v; e2d = e1d; e2t = e1t;
      e1v = 0;
      if (inValid) begin
        refAcc = refSat(inStart ? 140'd0 : refAcc, refToFix(inData));
        if (inLast) begin
          e1v = 1; e1d = refToFloat(refAcc); e1t = curTag;
        end
      end
    end
  end

  // R9: compare against the three-edge-deep expectation at every falling edge
  always @(negedge clk) begin
    if (rstN && !done && (e3v || outValid)) begin
      checks++;
      if (outValid !== e3v || (e3v && outData !== e3d)) begin
        errors++;
        $display("FAIL %s R9: outValid=%0b outData=%h expected valid=%0b data=%h",
                 e3t, outValid, outData, e3v, e3d);
      end
    end
  end

  task automatic put(input bit v, input bit s, input bit l, input logic [45:0] d,
                     input string tg);
    @(posedge clk); #1;
    inValid = v; inStart = s; inLast = l; inData = d; curTag = tg;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(0, 0, 0, '0, curTag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R9: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      errors++;
      $display("FAIL R11: outValid=%0b expected 0 after reset", outValid);
    end

    // R11: first input without start sums from zero (1.5)
    put(1, 0, 1, mk(0, 1023, 34'h2_0000_0000), "R11");
    idle(4);

    // R1 R6 R7: 1.5 + 2.25 - 0.5 = 3.25
    put(1, 1, 0, mk(0, 1023, 34'h2_0000_0000), "R6");
    put(1, 0, 0, mk(0, 1024, 34'h0_8000_0000), "R7");
    put(1, 0, 1, mk(1, 1022, 34'h0), "R1");
    // R7: continue past the last marker: 3.25 + 0.75
    put(1, 0, 1, mk(0, 1022, 34'h2_0000_0000), "R7");
    idle(4);

    // R2: zero exponent with garbage fraction and sign enters as zero
    put(1, 1, 0, mk(0, 1025, 34'h1_2345_6789), "R2");
    put(1, 0, 1, mk(1, 0, 34'h3_FFFF_FFFF), "R2");
    put(1, 1, 1, mk(1, 0, 34'h1_0000_0001), "R10");
    idle(4);

    // R3: tiny inputs truncated at 2^-100
    put(1, 1, 1, mk(0, 900, 34'h3_FFFF_FFFF), "R3");
    put(1, 1, 1, mk(1, 950, 34'h3_FFFF_FFFF), "R3");
    put(1, 1, 1, mk(0, 923, 34'h1_5555_5555), "R3");
    idle(4);

    // R4: entry saturation, positive and negative
    put(1, 1, 1, mk(0, 1062, 34'h0), "R4");
    put(1, 1, 1, mk(1, 2000, 34'h1_0000_0000), "R4");
    // R5: clamp on positive and negative overflow of the sum
    put(1, 1, 0, mk(0, 1061, 34'h3_0000_0000), "R5");
    put(1, 0, 1, mk(0, 1061, 34'h3_0000_0000), "R5");
    put(1, 1, 0, mk(1, 1070, 34'h0), "R5");
    put(1, 0, 1, mk(1, 1061, 34'h0), "R5");
    idle(4);

    // R10: 1 + 2^-50 truncates back to 1.0
    put(1, 1, 0, mk(0, 1023, 34'h0), "R10");
    put(1, 0, 1, mk(0, 973, 34'h0), "R10");
    // R10: exact cancellation gives the all-zero word
    put(1, 1, 0, mk(0, 1030, 34'h1_2300_0000), "R10");
    put(1, 0, 1, mk(1, 1030, 34'h1_2300_0000), "R10");
    idle(4);

    // R8: invalid slots with start/last/data set are ignored mid-sequence
    put(1, 1, 0, mk(0, 1024, 34'h0), "R8");
    put(0, 1, 1, mk(0, 1040, 34'h3_0000_0000), "R8");
    put(0, 1, 0, mk(1, 1035, 34'h0), "R8");
    put(1, 0, 1, mk(0, 1023, 34'h0), "R8");
    idle(4);

    // R9: back-to-back single-item sequences, one result per clock
    for (int k = 0; k < 6; k++) put(1, 1, 1, mk(k[0], 1020 + k, 34'(k * 77)), "R9");
    idle(4);

    // randomized sequences
    for (int n = 0; n < 400; n++) begin
      int len;
      bit fresh;
      len = 1 + int'($urandom % 6);
      fresh = ($urandom % 5) != 0;
      for (int i = 0; i < len; i++) begin
        int r;
        int e;
        logic [33:0] fr;
        r = int'($urandom % 10);
        fr = 34'({$urandom, $urandom});
        if (r == 0) e = 0;
        else if (r == 1) e = 900 + int'($urandom % 100);
        else e = 1000 + int'($urandom % 40);
        if (($urandom % 4) == 0)
          put(0, $urandom % 2, $urandom % 2, 46'({$urandom, $urandom}), "R8");
        put(1, fresh && i == 0, i == len - 1, mk($urandom % 2, e, fr), "R1");
      end
    end
    idle(6);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule